// File: doc/BRIEF.md
# Keyed Watchdog with Early-Warning Interrupt

The block is a down-counting watchdog timer on a simple register bus. A power-of-two prescaler produces count ticks, and each tick decrements a 12-bit counter. The counter starts from a programmed reload value. Software controls the block by writing 16-bit key codes to a key register. One key starts the timer. Another key refreshes the counter. A third key opens the prescaler and reload registers for writing. If software lets the counter run out, the block emits a one-cycle reset request.

An early-warning comparator watches the counter as it decrements. When the counter reaches a programmed compare value, the comparator raises a sticky interrupt, so software is warned before the reset fires. A new prescaler or reload value takes effect a fixed number of cycles after it is written. Two status bits show that such an update is still pending. Once started, the watchdog can only be stopped by the block's reset input.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `irq_o` and `wdg_rst_o` are 0, the status register reads 0, the reload register reads 0xFFF, the prescaler register reads 0 and the early-warning register reads 0.
- R2: Register word addresses are decoded from `addr_i[4:2]`: 0 key, 1 prescaler, 2 reload, 3 status, 5 early-warning control. Writing key 0x5555 (bits 15:0) unlocks the prescaler and reload registers. Writing any other key value relocks them. While they are locked, writes to them are ignored.
- R3: Status bit 0 (prescaler) and status bit 1 (reload) read 1 for UPD_LAT cycles after an accepted write to that register. The new value takes effect in the same edge at which the bit clears.
- R4: Key 0xCCCC starts the watchdog and loads the counter with the reload value R. With divide ratio D, `wdg_rst_o` rises (R+1)*D cycles after the start write.
- R5: The prescaler field holds bits 3:0. A value P from 0 to 8 gives D = 2^(P+2). Any value above 8 gives D = 1024. The register reads back the value that was written.
- R6: Key 0xAAAA reloads the counter and restarts the prescaler phase. Refreshing more often than every (R+1)*D cycles prevents any reset request.
- R7: `wdg_rst_o` is a one-cycle pulse. After the pulse the counter reloads and keeps counting. No key value stops a started watchdog.
- R8: Early-warning control bits 11:0 hold the compare value C, and bit 15 is the enable. When the enable is set and a tick decrements the counter to C, `irq_o` rises at that edge. When the enable is clear, `irq_o` never rises.
- R9: `irq_o` stays high until a write to the early-warning control register with bit 14 set. A refresh does not clear it. If the acknowledge and a new match fall on the same edge, `irq_o` stays high.
- R10: If a refresh key is written in the same cycle as the tick that would underflow the counter, the refresh wins and no reset request is produced.
- R11: The early-warning register reads back the compare value and enable, with bit 14 always reading 0. The key register always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 5 | Byte address; bits 4:2 select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Early-warning interrupt, sticky until acknowledged |
| wdg_rst_o | output | 1 | One-cycle reset request on counter underflow |

## Verification
Two pairs of events can land on the same edge, and both are checked. The first pair is a refresh key and the final tick that would underflow the counter. The bench counts the cycles since the previous reload and writes the refresh exactly on the terminal edge. It then expects no reset pulse and a full new period. The second pair is an interrupt acknowledge and the compare-match tick. The bench schedules the acknowledge write on the match edge and expects `irq_o` to stay high. A behavioural model, updated on every clock, judges all outputs and read data cycle by cycle.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [2:0] W_KEY = 3'd0;
  localparam logic [2:0] W_PRE = 3'd1;
  localparam logic [2:0] W_RLD = 3'd2;
  localparam logic [2:0] W_STS = 3'd3;
  localparam logic [2:0] W_EWC = 3'd5;

  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [15:0] KEY_UNLOCK  = 16'h5555;

  localparam int EWC_ACK_BIT = 14;
  localparam int EWC_EN_BIT  = 15;
endpackage

// File: rtl/kwd_divider.sv
module kwd_divider #(
  parameter int SEL_W    = 4,
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W   = MAX_LOG2;
  localparam int MAX_SEL = MAX_LOG2 - MIN_LOG2;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;
  int               shamt;

  always_comb begin
    if (int'(sel_i) > MAX_SEL) shamt = MAX_LOG2;
    else                       shamt = int'(sel_i) + MIN_LOG2;
    lim = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < shamt) lim[i] = 1'b1;
    end
  end

  // >= keeps the tick alive when the ratio shrinks mid-period
  assign tick_o = run_i && (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    div_q <= '0;
    else if (clr_i || !run_i)       div_q <= '0;
    else if (tick_o)                div_q <= '0;
    else                            div_q <= div_q + 1'b1;
  end

  // R4
  idle_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (div_q == '0));
endmodule

// File: rtl/kwd_shadow.sv
module kwd_shadow #(
  parameter int           W       = 12,
  parameter int           LAT     = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o,
  output logic         pend_o
);
  localparam int LAT_W = $clog2(LAT + 1);
  localparam logic [LAT_W-1:0] LAT_V = LAT_W'(LAT);

  logic [LAT_W-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_o <= RST_VAL;
      active_o <= RST_VAL;
      wait_q   <= '0;
    end else if (wr_i) begin
      shadow_o <= wdata_i;
      wait_q   <= LAT_V;
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
      if (wait_q == LAT_W'(1)) active_o <= shadow_o;
    end
  end

  assign pend_o = (wait_q != '0);

  // R3
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_o |=> $stable(active_o));
  // R3
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pend_o);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int PRE_W    = 4,
  parameter int UPD_LAT  = 3,
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 10,
  parameter int AW       = 5,
  parameter int DW       = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          wdg_rst_o
);
  logic [2:0]  word;
  logic [15:0] key;
  logic        wr, key_wr, start_key, reload_evt, pre_wr, rld_wr, ewc_wr, ack;
  logic        unlock_q, run_q, irq_q, rst_q, en_q;
  logic [CNT_W-1:0] cnt_q, cmp_q, rld_sh, rld_act;
  logic [PRE_W-1:0] pre_sh, pre_act;
  logic        pre_pend, rld_pend, tick, underflow, match;
  logic        unused_bits;

  assign word       = addr_i[4:2];
  assign key        = wdata_i[15:0];
  assign wr         = req_i && we_i;
  assign key_wr     = wr && (word == W_KEY);
  assign start_key  = key_wr && (key == KEY_START);
  assign reload_evt = key_wr && (key == KEY_START || key == KEY_REFRESH);
  assign pre_wr     = wr && (word == W_PRE) && unlock_q;
  assign rld_wr     = wr && (word == W_RLD) && unlock_q;
  assign ewc_wr     = wr && (word == W_EWC);
  assign ack        = ewc_wr && wdata_i[EWC_ACK_BIT];
  assign unused_bits = ^{addr_i[1:0], wdata_i[DW-1:16], wdata_i[13:CNT_W]};

  kwd_shadow #(.W(PRE_W), .LAT(UPD_LAT), .RST_VAL('0)) u_pre (
    .clk_i, .rst_ni, .wr_i(pre_wr), .wdata_i(wdata_i[PRE_W-1:0]),
    .shadow_o(pre_sh), .active_o(pre_act), .pend_o(pre_pend));

  kwd_shadow #(.W(CNT_W), .LAT(UPD_LAT), .RST_VAL('1)) u_rld (
    .clk_i, .rst_ni, .wr_i(rld_wr), .wdata_i(wdata_i[CNT_W-1:0]),
    .shadow_o(rld_sh), .active_o(rld_act), .pend_o(rld_pend));

  kwd_divider #(.SEL_W(PRE_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_div (
    .clk_i, .rst_ni, .run_i(run_q), .clr_i(reload_evt), .sel_i(pre_act),
    .tick_o(tick));

  assign underflow = tick && (cnt_q == '0) && !reload_evt;
  assign match     = tick && !reload_evt && en_q && (cnt_q != '0) &&
                     ((cnt_q - 1'b1) == cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      run_q    <= 1'b0;
      cnt_q    <= '1;
      rst_q    <= 1'b0;
      irq_q    <= 1'b0;
      cmp_q    <= '0;
      en_q     <= 1'b0;
    end else begin
      if (key_wr)    unlock_q <= (key == KEY_UNLOCK);
      if (start_key) run_q    <= 1'b1;
      if (reload_evt)     cnt_q <= rld_act;
      else if (underflow) cnt_q <= rld_act;
      else if (tick)      cnt_q <= cnt_q - 1'b1;
      rst_q <= underflow;
      if (match)    irq_q <= 1'b1;
      else if (ack) irq_q <= 1'b0;
      if (ewc_wr) begin
        cmp_q <= wdata_i[CNT_W-1:0];
        en_q  <= wdata_i[EWC_EN_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (word)
      W_PRE: rdata_o[PRE_W-1:0] = pre_sh;
      W_RLD: rdata_o[CNT_W-1:0] = rld_sh;
      W_STS: rdata_o[1:0]       = {rld_pend, pre_pend};
      W_EWC: begin
        rdata_o[CNT_W-1:0]  = cmp_q;
        rdata_o[EWC_EN_BIT] = en_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign irq_o     = irq_q;
  assign wdg_rst_o = rst_q;

  // R7
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_rst_o |=> !wdg_rst_o);
  // R7
  no_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q);
  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack) |=> irq_o);
  // R2
  locked_rld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word == W_RLD && !unlock_q) |=> $stable(rld_sh));
  // R10
  refresh_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_evt |=> !wdg_rst_o);
endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = 5'h0C;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wrst;

  always #4 clk = ~clk;

  keyed_watchdog dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wdg_rst_o(wrst));

  int checks = 0, errors = 0, cyc = 0;

  // behavioural reference state
  int m_run, m_cnt, m_div, m_pre_sh, m_pre_act, m_rld_sh, m_rld_act;
  int m_pp, m_rp, m_unl, m_cmp, m_en, m_irq, m_rst;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int m_read(logic [4:0] a);
    case (a[4:2])
      3'd1: return m_pre_sh;
      3'd2: return m_rld_sh;
      3'd3: return ((m_rp != 0) ? 2 : 0) + ((m_pp != 0) ? 1 : 0);
      3'd5: return m_en * 32768 + m_cmp;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    int w, k, lim, sh;
    bit wr, kw, rel, tick, und, mt, ack;
    w  = int'(addr[4:2]);
    wr = req && we;
    kw = wr && (w == 0);
    k  = int'(wdata[15:0]);
    rel = kw && (k == 'hCCCC || k == 'hAAAA);
    sh  = (m_pre_act > 8) ? 10 : m_pre_act + 2;
    lim = (1 << sh) - 1;
    tick = (m_run != 0) && (m_div >= lim);
    und  = tick && (m_cnt == 0) && !rel;
    mt   = tick && !rel && (m_cnt != 0) && (m_en != 0) && (m_cnt - 1 == m_cmp);
    ack  = wr && (w == 5) && wdata[14];
    if (rel || m_run == 0 || tick) m_div = 0; else m_div = m_div + 1;
    if (rel) m_cnt = m_rld_act;
    else if (tick) m_cnt = (m_cnt == 0) ? m_rld_act : m_cnt - 1;
    m_rst = und;
    if (mt) m_irq = 1; else if (ack) m_irq = 0;
    if (kw && k == 'hCCCC) m_run = 1;
    if (wr && w == 1 && m_unl != 0) begin m_pre_sh = int'(wdata[3:0]); m_pp = 3; end
    else if (m_pp > 0) begin if (m_pp == 1) m_pre_act = m_pre_sh; m_pp--; end
    if (wr && w == 2 && m_unl != 0) begin m_rld_sh = int'(wdata[11:0]); m_rp = 3; end
    else if (m_rp > 0) begin if (m_rp == 1) m_rld_act = m_rld_sh; m_rp--; end
    if (wr && w == 5) begin m_cmp = int'(wdata[11:0]); m_en = int'(wdata[15]); end
    if (kw) m_unl = (k == 'h5555);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 'hFFF; m_div = 0; m_pre_sh = 0; m_pre_act = 0;
      m_rld_sh = 'hFFF; m_rld_act = 'hFFF; m_pp = 0; m_rp = 0; m_unl = 0;
      m_cmp = 0; m_en = 0; m_irq = 0; m_rst = 0;
    end else model_step();
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      #1;
      chk("R8 R9 model irq", {31'd0, irq}, 32'(m_irq));
      chk("R4 R7 model rst", {31'd0, wrst}, 32'(m_rst));
      chk("R2 R3 R11 model rdata", rdata, 32'(m_read(addr)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic bus_wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0; addr = 5'h0C; wdata = '0;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_rst(input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(negedge clk); n++;
      #1;
      if (wrst) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    int n;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 rst", {31'd0, wrst}, 0);
    bus_rd(5'h08, v); chk("R1 reload", v, 32'hFFF);
    bus_rd(5'h04, v); chk("R1 prescaler", v, 0);
    bus_rd(5'h0C, v); chk("R1 status", v, 0);
    bus_rd(5'h14, v); chk("R1 ewc", v, 0);

    bus_wr(5'h08, 5);
    bus_rd(5'h08, v); chk("R2 locked reload", v, 32'hFFF);
    bus_rd(5'h0C, v); chk("R2 locked status", v, 0);

    bus_wr(5'h00, 32'h5555);
    bus_wr(5'h08, 5);
    bus_rd(5'h0C, v); chk("R3 pending", v, 2);
    repeat (3) @(negedge clk);
    bus_rd(5'h0C, v); chk("R3 cleared", v, 0);
    bus_rd(5'h08, v); chk("R3 reload", v, 5);
    bus_wr(5'h00, 32'h1234);
    bus_wr(5'h08, 9);
    bus_wr(5'h04, 3);
    bus_rd(5'h08, v); chk("R2 relocked reload", v, 5);
    bus_rd(5'h04, v); chk("R2 relocked prescaler", v, 0);

    bus_wr(5'h14, 32'h0002);
    bus_wr(5'h00, 32'hCCCC);
    n = 0; seen = 0;
    while (n < 200) begin
      @(negedge clk); n++; #1;
      seen |= irq;
      if (wrst) break;
    end
    chk("R4 first period", n, 24);
    chk("R8 disabled irq", {31'd0, seen}, 0);
    @(negedge clk); #1;
    chk("R7 pulse width", {31'd0, wrst}, 0);
    wait_rst(200, n);
    chk("R7 keeps running", n, 23);

    bus_wr(5'h14, 32'h8002);
    bus_rd(5'h14, v); chk("R11 ewc read", v, 32'h8002);
    bus_rd(5'h00, v); chk("R11 key read", v, 0);

    bus_wr(5'h00, 32'hAAAA);
    n = 0;
    while (n < 200) begin
      @(negedge clk); n++; #1;
      if (irq) break;
    end
    chk("R8 match time", n, 12);
    bus_wr(5'h00, 32'hAAAA); #1;
    chk("R9 refresh keeps irq", {31'd0, irq}, 1);
    bus_wr(5'h14, 32'hC002); #1;
    chk("R9 ack clears", {31'd0, irq}, 0);
    bus_rd(5'h14, v); chk("R11 ack bit reads 0", v, 32'h8002);

    bus_wr(5'h00, 32'hAAAA);
    repeat (10) @(negedge clk);
    bus_wr(5'h14, 32'hC002); #1;
    chk("R9 match beats ack", {31'd0, irq}, 1);
    bus_wr(5'h14, 32'hC002); #1;
    chk("R9 second ack", {31'd0, irq}, 0);

    bus_wr(5'h00, 32'hAAAA);
    repeat (22) @(negedge clk);
    bus_wr(5'h00, 32'hAAAA); #1;
    seen = wrst;
    repeat (22) begin @(negedge clk); #1; seen |= wrst; end
    chk("R10 refresh on terminal tick", {31'd0, seen}, 0);

    seen = 0;
    for (int i = 0; i < 10; i++) begin
      bus_wr(5'h00, 32'hAAAA);
      repeat (12) begin @(negedge clk); #1; seen |= wrst; end
    end
    chk("R6 steady refresh", {31'd0, seen}, 0);

    bus_wr(5'h00, 32'h5555);
    bus_wr(5'h04, 1);
    repeat (4) @(negedge clk);
    bus_rd(5'h0C, v); chk("R5 status", v, 0);
    bus_wr(5'h00, 32'hAAAA);
    wait_rst(500, n);
    chk("R5 divide by 8", n, 48);

    bus_wr(5'h00, 32'h5555);
    bus_wr(5'h04, 15);
    repeat (4) @(negedge clk);
    bus_rd(5'h04, v); chk("R5 readback", v, 15);
    bus_wr(5'h00, 32'h0000);
    bus_wr(5'h00, 32'hAAAA);
    wait_rst(10000, n);
    chk("R5 clamp 1024", n, 6144);

    bus_wr(5'h00, 32'h0000);
    wait_rst(10000, n);
    chk("R7 unstoppable", {31'd0, wrst}, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule